// File: doc/BRIEF.md
# SPI Burst Master

This block is a host-side SPI master for a memory-card style serial device. Software controls it through a small byte-wide register window. It fills a transmit byte queue, programs how many bytes the next burst moves, and then writes a control byte. That control byte selects the serial clock rate, the level of the device select line, the transfer direction and an internal loopback path. The same control byte enables the master and starts the burst.

Each exchange moves 1 to 8 bytes in SPI mode 0 with the most significant bit first. In send mode the queued bytes go out on MOSI and whatever arrives on MISO is thrown away. In receive mode MOSI idles high and the incoming bytes are stored in a receive queue, which software drains one byte per read. At the end of a burst, sticky status flags are set and the interrupt line goes high. A single read of the status register clears all of them. Writing zero to the reset location returns the whole block to its reset state, and this also aborts a burst in progress.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, the register reads are: control (offset 0x00) 0x20, status (0x04) 0x00 and count (0x08) 0x00. The outputs are sclk 0, mosi 1, cs_n 1 and irq 0.
- R2: Control bit 5 drives cs_n directly. Control bit 6 sets the sclk half-period: 1 clk cycle when the bit is 0, 2 clk cycles when it is 1. A burst of n bytes sets its end flags exactly 16·n·h clk edges after the edge that accepted the start.
- R3: In send mode (control bit 4 = 0) each byte goes out MSB first in SPI mode 0. MOSI changes only when sclk falls or when a burst starts, and bytes leave in the order they were pushed into the TX register (offset 0x0C).
- R4: In receive mode (control bit 4 = 1), MOSI stays 1. A bit is sampled at each sclk rising edge, and each completed byte is stored. Reads of offset 0x10 return the stored bytes oldest first, and return 0x00 when the queue is empty. In send mode no byte is stored.
- R5: With control bit 2 set, the receive input is taken from MOSI and the MISO pin is ignored.
- R6: A burst starts only when a control write has bit 0 = 1 and bit 1 = 1, the block is idle and the count is nonzero. Otherwise no sclk edge occurs. Bit 0 always reads back 0.
- R7: While a burst runs, writes to control, count and TX are ignored.
- R8: Status bit 6 is set at the end of every burst. Bit 7 is set at the end of a send burst, and bit 5 at the end of a receive burst. Bits 4..0 read 0. irq is high while any flag is set.
- R9: A read of the status register clears all flags and drops irq.
- R10: Count writes above 8 are stored as 8. TX holds 8 bytes and further pushes are ignored. Burst slots beyond the pushed bytes are sent as 0x00.
- R11: The RX queue rewinds when a burst starts. The TX queue rewinds when a burst ends, so the next pushes fill it from the first slot.
- R12: Writing 0x00 to offset 0x1C returns the block to its R1 state, including aborting a running burst. Writing a nonzero value there has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pop and clear take effect at the edge) |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq | output | 1 | High while any status flag is set |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out, idles high |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Device select, copy of control bit 5 |

## Verification
Register read data is due in the same cycle as the read strobe. The bench therefore samples bus_rdata 1 ns after driving the strobe on a falling edge, and the pop or flag clear it causes is checked on a later access. End-of-burst flags and irq are due 16·n·h edges after the start edge. A free-running edge counter timestamps the start write, and the elapsed count when irq rises is compared with that figure. Serial data is checked bit by bit at each sclk rising edge, where mode 0 defines the sample point. Flag clears and aborts are checked by reads after those edges.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_CNT  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_TXD  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_RXD  = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_SRST = 5'h1C;

    // Stored control fields (start is a strobe and is never stored)
    typedef struct packed {
        logic half_div;  // bit 6: 1 -> sclk half-period of two clk cycles
        logic cs_hi;     // bit 5: level driven on cs_n
        logic recv;      // bit 4: 1 -> receive direction
        logic loop;      // bit 2: receive input taken from mosi
        logic en;        // bit 1: master enable
    } ctrl_t;

    typedef struct packed {
        logic tx_empty;  // bit 7
        logic done;      // bit 6
        logic rx_full;   // bit 5
    } flags_t;

    localparam ctrl_t CTRL_RST = '{half_div: 1'b0, cs_hi: 1'b1, recv: 1'b0,
                                   loop: 1'b0, en: 1'b0};

    function automatic logic [DATA_W-1:0] ctrl_image(ctrl_t c);
        return {1'b0, c.half_div, c.cs_hi, c.recv, 1'b0, c.loop, c.en, 1'b0};
    endfunction

    function automatic logic [DATA_W-1:0] stat_image(flags_t f);
        return {f.tx_empty, f.done, f.rx_full, 5'b00000};
    endfunction

endpackage

// File: rtl/spi_bm_bytebuf.sv
module spi_bm_bytebuf #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int PW = $clog2(DEPTH+1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic          full, empty;

    assign full  = (wp_q == PW'(DEPTH));
    assign empty = (rp_q == wp_q);
    assign dout  = empty ? '0 : mem[rp_q[IW-1:0]];
    assign level = wp_q - rp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= '0;
            rp_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (clr) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (push && !full) begin
                mem[wp_q[IW-1:0]] <= din;
                wp_q <= wp_q + 1'b1;
            end
            if (pop && !empty) rp_q <= rp_q + 1'b1;
        end
    end

    // R10: a push into a full queue leaves the write pointer where it was
    a_r10_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        (full && push && !clr) |=> (wp_q == PW'(DEPTH)));

    // R4: a pop from an empty queue does not move the read pointer
    a_r4_empty_pop_dropped: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !clr && !push) |=> (rp_q == $past(rp_q)));

endmodule

// File: rtl/spi_bm_engine.sv
module spi_bm_engine #(
    parameter int W     = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             half_div,
    input  logic             recv,
    input  logic             loop,
    input  logic             miso,
    input  logic [CNT_W-1:0] count,
    input  logic [W-1:0]     tx_byte,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [W-1:0]     rx_byte,
    output logic             sclk,
    output logic             mosi,
    output logic             busy,
    output logic             done
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    logic             busy_q, sclk_q, hp_q;
    logic [BW-1:0]    bit_q;
    logic [CNT_W-1:0] byte_q;
    logic [W-1:0]     tx_sh, rx_sh;
    logic             tick, last_bit, last_byte, byte_end, rx_in;

    assign tick      = busy_q && (hp_q == half_div);
    assign last_bit  = (bit_q == BW'(W-1));
    assign last_byte = (byte_q == count - 1'b1);
    assign byte_end  = tick && sclk_q && last_bit;

    assign mosi    = (busy_q && !recv) ? tx_sh[W-1] : 1'b1;
    assign rx_in   = loop ? mosi : miso;
    assign rx_push = byte_end && recv;
    assign rx_byte = rx_sh;
    assign done    = byte_end && last_byte;
    assign tx_pop  = (go && !busy_q) || (byte_end && !last_byte);
    assign sclk    = sclk_q;
    assign busy    = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            hp_q   <= 1'b0;
            bit_q  <= '0;
            byte_q <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else if (!busy_q) begin
            if (go) begin
                busy_q <= 1'b1;
                tx_sh  <= tx_byte;
                bit_q  <= '0;
                byte_q <= '0;
                sclk_q <= 1'b0;
                hp_q   <= 1'b0;
            end
        end else if (!tick) begin
            hp_q <= 1'b1;
        end else begin
            hp_q <= 1'b0;
            if (!sclk_q) begin
                sclk_q <= 1'b1;
                rx_sh  <= {rx_sh[W-2:0], rx_in};
            end else begin
                sclk_q <= 1'b0;
                if (last_bit) begin
                    bit_q <= '0;
                    if (last_byte) begin
                        busy_q <= 1'b0;
                    end else begin
                        tx_sh  <= tx_byte;
                        byte_q <= byte_q + 1'b1;
                    end
                end else begin
                    tx_sh <= {tx_sh[W-2:0], 1'b0};
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end

    // R3: mode 0 - outgoing data only moves on a falling sclk
    a_r3_mosi_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && !$fell(sclk_q)) |-> $stable(mosi));

    // R2: the serial clock rests low between bursts
    a_r2_sclk_low_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !sclk_q);

    // R4: receive bursts keep mosi high
    a_r4_recv_mosi_high: assert property (@(posedge clk) disable iff (rst)
        (busy_q && recv) |-> mosi);

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
    import spi_bm_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [4:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n
);
    localparam int CNT_W = $clog2(DEPTH+1);

    ctrl_t             ctrl_q;
    flags_t            flags_q, flags_set;
    logic [CNT_W-1:0]  count_q;
    logic              srst, wr_idle, go, stat_rd, rx_rd;
    logic              eng_busy, eng_done, tx_pop, rx_push;
    logic [DATA_W-1:0] tx_byte, rx_byte, rx_head;
    logic [CNT_W-1:0]  tx_level, rx_level;

    assign srst    = rst || (bus_wr && bus_addr == OFF_SRST && bus_wdata == '0);
    assign wr_idle = bus_wr && !eng_busy;
    assign go      = wr_idle && bus_addr == OFF_CTRL && bus_wdata[0] && bus_wdata[1]
                     && count_q != '0;
    assign stat_rd = bus_rd && bus_addr == OFF_STAT;
    assign rx_rd   = bus_rd && bus_addr == OFF_RXD;

    always_ff @(posedge clk) begin
        if (srst) begin
            ctrl_q  <= CTRL_RST;
            count_q <= '0;
        end else if (wr_idle) begin
            if (bus_addr == OFF_CTRL) begin
                ctrl_q <= '{half_div: bus_wdata[6], cs_hi: bus_wdata[5],
                            recv: bus_wdata[4], loop: bus_wdata[2], en: bus_wdata[1]};
            end
            if (bus_addr == OFF_CNT) begin
                if (bus_wdata > 8'(DEPTH)) count_q <= CNT_W'(DEPTH);
                else                       count_q <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    assign flags_set = '{tx_empty: eng_done && !ctrl_q.recv,
                         done:     eng_done,
                         rx_full:  eng_done && ctrl_q.recv};

    always_ff @(posedge clk) begin
        if (srst)         flags_q <= '0;
        else if (stat_rd) flags_q <= flags_set;
        else              flags_q <= flags_q | flags_set;
    end

    spi_bm_bytebuf #(.DEPTH(DEPTH), .W(DATA_W)) u_txq (
        .clk(clk), .rst(srst), .clr(eng_done),
        .push(wr_idle && bus_addr == OFF_TXD), .din(bus_wdata),
        .pop(tx_pop), .dout(tx_byte), .level(tx_level)
    );

    spi_bm_bytebuf #(.DEPTH(DEPTH), .W(DATA_W)) u_rxq (
        .clk(clk), .rst(srst), .clr(go),
        .push(rx_push), .din(rx_byte),
        .pop(rx_rd), .dout(rx_head), .level(rx_level)
    );

    spi_bm_engine #(.W(DATA_W), .CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst(srst), .go(go),
        .half_div(ctrl_q.half_div), .recv(ctrl_q.recv), .loop(ctrl_q.loop),
        .miso(miso), .count(count_q), .tx_byte(tx_byte),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
        .sclk(sclk), .mosi(mosi), .busy(eng_busy), .done(eng_done)
    );

    always_comb begin
        case (bus_addr)
            OFF_CTRL: bus_rdata = ctrl_image(ctrl_q);
            OFF_STAT: bus_rdata = stat_image(flags_q);
            OFF_CNT:  bus_rdata = 8'(count_q);
            OFF_RXD:  bus_rdata = rx_head;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq  = |flags_q;
    assign cs_n = ctrl_q.cs_hi;

    // R8: the end of a burst raises the interrupt on the next cycle
    a_r8_done_raises_irq: assert property (@(posedge clk) disable iff (srst)
        eng_done |=> irq);

    // R9: a status read with no burst ending clears the interrupt
    a_r9_read_clears: assert property (@(posedge clk) disable iff (srst)
        (stat_rd && !eng_done) |=> !irq);

    // R7: register writes during a burst leave control and count untouched
    a_r7_busy_writes_ignored: assert property (@(posedge clk) disable iff (srst)
        (eng_busy && bus_wr) |=> ($stable(ctrl_q) && $stable(count_q)));

    // R6: the engine only becomes busy on an accepted start
    a_r6_start_gated: assert property (@(posedge clk) disable iff (srst)
        (!eng_busy && !go) |=> !eng_busy);

    // R11: RX rewinds at start, TX rewinds at end
    a_r11_rx_rewind: assert property (@(posedge clk) disable iff (srst)
        go |=> (rx_level == '0));
    a_r11_tx_rewind: assert property (@(posedge clk) disable iff (srst)
        eng_done |=> (tx_level == '0));

endmodule

// File: tb/spi_burst_master_test.sv
module spi_burst_master_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, sclk, mosi, miso, cs_n;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    logic [7:0] sl  [8];
    logic [7:0] cap [8];
    logic [7:0] txv [10];
    int rise_total = 0;
    int rise_base  = 0;

    spi_burst_master uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    // Device model: captures mosi and advances miso on rising sclk
    always @(posedge sclk) begin
        int r;
        r = rise_total - rise_base;
        if (r >= 0 && r < 64) cap[r/8][7 - (r%8)] = mosi;
        rise_total = rise_total + 1;
    end

    always_comb begin
        int r;
        r = rise_total - rise_base;
        if (r >= 0 && r < 64) miso = sl[r/8][7 - (r%8)];
        else                  miso = 1'b0;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_irq(input int c0, output int k);
        while (!irq && (cyc - c0) < 3000) begin
            @(posedge clk); #1;
        end
        k = cyc - c0;
    endtask

    function automatic int burst_len(input int n, input bit h);
        return 16 * n * (h ? 2 : 1);
    endfunction

    task automatic run_xfer(input int n, input bit h, input bit rcv, input bit lp, input int p);
        logic [7:0] d;
        int c0, k, kept;
        bw(5'h08, 8'(n));
        for (int i = 0; i < p; i++) begin
            txv[i] = 8'($urandom);
            bw(5'h0C, txv[i]);
        end
        for (int i = 0; i < 8; i++) sl[i] = 8'($urandom);
        rise_base = rise_total;
        bw(5'h00, {1'b0, h, 1'b0, rcv, 1'b0, lp, 1'b1, 1'b1});
        c0 = cyc;
        wait_irq(c0, k);
        chk("R2 burst length", k, burst_len(n, h));
        chk("R2 sclk edge count", rise_total - rise_base, 8 * n);
        kept = (p > 8) ? 8 : p;
        for (int i = 0; i < n; i++) begin
            if (rcv) chk("R4 mosi held high", cap[i], 8'hFF);
            else     chk("R3 R10 sent byte", cap[i], (i < kept) ? txv[i] : 8'h00);
        end
        br(5'h04, d);
        chk("R8 status flags", d, rcv ? 8'h60 : 8'hC0);
        #1 chk("R9 irq after status read", irq, 0);
        br(5'h04, d);
        chk("R9 status cleared", d, 8'h00);
        if (rcv) begin
            for (int i = 0; i < n; i++) begin
                br(5'h10, d);
                chk(lp ? "R5 loopback byte" : "R4 received byte", d, lp ? 8'hFF : sl[i]);
            end
        end
        br(5'h10, d);
        chk("R4 R11 RX empty after drain", d, 8'h00);
    endtask

    initial begin
        logic [7:0] d;
        int c0, k, r0;
        void'($urandom(32'h5EED_0417));
        for (int i = 0; i < 8; i++) sl[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        #1;
        chk("R1 sclk", sclk, 0);
        chk("R1 mosi", mosi, 1);
        chk("R1 cs_n", cs_n, 1);
        chk("R1 irq", irq, 0);
        br(5'h00, d); chk("R1 ctrl", d, 8'h20);
        br(5'h04, d); chk("R1 status", d, 8'h00);
        br(5'h08, d); chk("R1 count", d, 8'h00);

        // R2 chip select follows control bit 5
        bw(5'h00, 8'h00); #1 chk("R2 cs_n low", cs_n, 0);
        bw(5'h00, 8'h20); #1 chk("R2 cs_n high", cs_n, 1);

        // R10 count clamp
        bw(5'h08, 8'h0F); br(5'h08, d); chk("R10 count clamp", d, 8'h08);
        bw(5'h08, 8'h03); br(5'h08, d); chk("R10 count plain", d, 8'h03);

        // R6 start without enable
        r0 = rise_total;
        bw(5'h00, 8'h01);
        repeat (60) @(posedge clk);
        #1 chk("R6 no irq when disabled", irq, 0);
        chk("R6 no sclk when disabled", rise_total - r0, 0);
        br(5'h00, d); chk("R6 start reads 0", d, 8'h00);

        // R6 count of zero
        bw(5'h08, 8'h00);
        bw(5'h00, 8'h03);
        repeat (60) @(posedge clk);
        #1 chk("R6 no irq on zero count", irq, 0);
        chk("R6 no sclk on zero count", rise_total - r0, 0);

        // R10 overflow of TX queue
        run_xfer(8, 1'b0, 1'b0, 1'b0, 10);

        // R7 writes during a burst
        bw(5'h08, 8'h04);
        rise_base = rise_total;
        bw(5'h00, 8'h03);
        c0 = cyc;
        bw(5'h00, 8'h63);
        bw(5'h08, 8'h01);
        bw(5'h0C, 8'hA5);
        wait_irq(c0, k);
        chk("R7 burst unaffected", k, burst_len(4, 1'b0));
        br(5'h00, d); chk("R7 ctrl kept", d, 8'h02);
        br(5'h08, d); chk("R7 count kept", d, 8'h04);
        br(5'h04, d); chk("R8 send flags", d, 8'hC0);

        // R12 soft reset aborts a burst
        bw(5'h08, 8'h08);
        bw(5'h00, 8'h43);
        repeat (20) @(posedge clk);
        bw(5'h1C, 8'h00);
        #1 chk("R12 sclk low", sclk, 0);
        chk("R12 mosi high", mosi, 1);
        r0 = rise_total;
        repeat (300) @(posedge clk);
        #1 chk("R12 no irq after abort", irq, 0);
        chk("R12 no sclk after abort", rise_total - r0, 0);
        chk("R12 cs_n", cs_n, 1);
        br(5'h00, d); chk("R12 ctrl", d, 8'h20);
        br(5'h08, d); chk("R12 count", d, 8'h00);
        br(5'h04, d); chk("R12 status", d, 8'h00);
        bw(5'h00, 8'h14);
        bw(5'h1C, 8'h5A);
        br(5'h00, d); chk("R12 nonzero write ignored", d, 8'h14);

        // Directed: loopback receive, slow rate
        run_xfer(3, 1'b1, 1'b1, 1'b1, 0);

        // Random mix
        for (int it = 0; it < 24; it++) begin
            run_xfer($urandom_range(8, 1), 1'($urandom), 1'($urandom),
                     1'($urandom), $urandom_range(8, 0));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule